// File: doc/BRIEF.md
# Serial ADC Conversion Master

This block is the host side of a four-wire serial link to an 8-bit successive-approximation converter with an addressable input multiplexer. A request picks an input: a single-ended channel, or an adjacent pair in differential mode with a chosen polarity. The block then runs one complete transaction. It pulls the select line low, produces a serial clock by dividing the system clock, shifts out a start bit and the multiplexer address, and waits for the converter's busy-status line. It then reads the result twice: first most-significant bit first, and then, after lowering the shift-enable line, as the least-significant-first replay of the stored word.

When the transaction ends, the block releases the select line and pulses `done`. The MSB-first word appears on `result`, and `mismatch` shows whether the two copies disagree. The block refuses new requests until the select line has been high for the minimum release time. The serial clock divider is checked at elaboration against the converter's legal clock range. A requested value outside that range is moved to the nearest legal value.

Top module: `adc_serial_host`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `adc_cs_n`=1, `adc_se_n`=1, `adc_sclk`=0, `busy`=0 and `done`=0.
- R2: A request (`req_valid`=1 while `busy`=0) is accepted at the next clock edge. At that same edge `adc_cs_n` goes low and `busy` goes high. `adc_sclk` idles low, and its first rising edge comes one half-period after `adc_cs_n` falls.
- R3: The host presents a start bit of 1 and then four address bits at the first five rising `adc_sclk` edges. `adc_di` changes only together with a falling `adc_sclk` edge or the fall of `adc_cs_n`. The address is {mode, odd, sel1, sel0}. For single-ended mode it is {1, chan[0], chan[2], chan[1]}. For differential mode it is {0, swap, chan[2], chan[1]}.
- R4: Each `adc_sclk` phase lasts exactly H system cycles. H is `HALF_DIV` clamped to the range ceil(SYS/1.2 MHz) to floor(SYS/20 kHz), so the serial clock stays between 10 and 600 kHz with a 50 % duty cycle.
- R5: After the address, the host waits for a rising `adc_sclk` edge with `adc_status`=1. At that edge and the next seven it samples `adc_do`, MSB first, and the word formed this way is `result`.
- R6: `adc_se_n` goes low at the falling edge that follows the eighth MSB-first sample, so the converter first sees it low at the 14th rising edge. It stays low until `adc_cs_n` rises, and it is never low while `adc_cs_n` is high.
- R7: The next eight rising edges sample the least-significant-first replay. `mismatch`=1 exactly when that replay, bit-reversed, differs from `result`.
- R8: `adc_cs_n` rises at the falling edge after the last replay sample, which is after 21 rising edges in all. `done` is high for exactly that one cycle, with `result` and `mismatch` valid.
- R9: After `adc_cs_n` rises, `busy` stays high for exactly C = ceil(`CS_HIGH_NS`·SYS/1e9) cycles. During that time `adc_cs_n` stays high, so every high pulse lasts at least C cycles.
- R10: A request presented while `busy`=1 is ignored. It starts no transaction and does not change the next transaction's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Conversion request |
| req_single | input | 1 | 1 = single-ended, 0 = differential |
| req_chan | input | 3 | Channel (single) or pair index in bits 2:1 (differential) |
| req_swap | input | 1 | Differential polarity swap |
| busy | output | 1 | Transaction or release hold in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 8 | MSB-first conversion word |
| mismatch | output | 1 | Replay disagrees with the MSB-first word |
| adc_cs_n | output | 1 | Converter select, active low |
| adc_sclk | output | 1 | Serial clock |
| adc_di | output | 1 | Serial data to converter |
| adc_se_n | output | 1 | Shift enable for the replay, active low |
| adc_do | input | 1 | Serial data from converter |
| adc_status | input | 1 | Converter conversion-in-progress line |

## Verification
The bench builds the block with a 200 MHz `SYS_CLK_HZ`, `HALF_DIV`=100 and `CS_HIGH_NS`=220. The requested divider is faster than the legal limit, so the clamp to 167 cycles per phase is exercised, and every measured phase must equal that value. The 220 ns release time gives a 44-cycle hold. This is short enough that back-to-back requests and requests issued during the hold both occur within the run. A behavioural converter model in the bench also injects corrupted replay bits, which makes the mismatch path reachable.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

    typedef int unsigned u32_t;

    localparam u32_t WORD_W = 8;
    localparam u32_t SEL_W  = 2;
    localparam u32_t CHAN_W = SEL_W + 1;
    localparam u32_t ADDR_W = SEL_W + 2;

    localparam longint unsigned SCLK_MAX_HZ = 600_000;
    localparam longint unsigned SCLK_MIN_HZ = 10_000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WAIT,
        ST_MSB,
        ST_SE,
        ST_LSB,
        ST_FIN,
        ST_HOLD
    } host_state_e;

    typedef struct packed {
        logic              single;
        logic [CHAN_W-1:0] chan;
        logic              swap;
    } conv_req_t;

    // Phase length in system cycles, forced into the legal serial clock range.
    function automatic u32_t clamp_half(longint unsigned sys_hz, longint unsigned want);
        longint unsigned lo;
        longint unsigned hi;
        longint unsigned pick;
        lo = (sys_hz + 2 * SCLK_MAX_HZ - 1) / (2 * SCLK_MAX_HZ);
        hi = sys_hz / (2 * SCLK_MIN_HZ);
        if (lo < 1) lo = 1;
        if (hi < lo) hi = lo;
        pick = want;
        if (pick < lo) pick = lo;
        if (pick > hi) pick = hi;
        return u32_t'(pick);
    endfunction

    // Minimum select-high time expressed in system cycles (rounded up).
    function automatic u32_t hold_cycles(longint unsigned sys_hz, longint unsigned ns);
        longint unsigned c;
        c = (ns * sys_hz + 64'd999_999_999) / 64'd1_000_000_000;
        if (c < 1) c = 1;
        return u32_t'(c);
    endfunction

    // Multiplexer address sent after the start bit: {mode, odd, sel}.
    function automatic logic [ADDR_W-1:0] addr_code(conv_req_t r);
        logic odd;
        odd = r.single ? r.chan[0] : r.swap;
        return {r.single, odd, r.chan[CHAN_W-1:1]};
    endfunction

endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
    parameter int unsigned HALF = 167
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic sclk,
    output logic rise_p,
    output logic fall_p
);
    localparam int unsigned CW = (HALF < 2) ? 1 : $clog2(HALF);

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick   = en && (cnt == CW'(HALF - 1));
    assign rise_p = tick && !sclk;
    assign fall_p = tick && sclk;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (tick) begin
            cnt  <= '0;
            sclk <= !sclk;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R4: the serial clock parks low whenever the divider is not running
    a_r4_sclk_parks_low: assert property (@(posedge clk) disable iff (rst)
        !en |=> !sclk);

endmodule

// File: rtl/adc_host_seq.sv
module adc_host_seq
    import adc_host_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 44
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  conv_req_t         req,
    input  logic              rise_p,
    input  logic              fall_p,
    input  logic              adc_do,
    input  logic              adc_status,
    output logic              cs_n,
    output logic              di,
    output logic              se_n,
    output logic              busy,
    output logic              sclk_en,
    output logic              done,
    output logic [WORD_W-1:0] msb_word,
    output logic [WORD_W-1:0] lsb_stream
);
    localparam int unsigned BCW = $clog2(ADDR_W + WORD_W + 1);
    localparam int unsigned HCW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC);

    host_state_e      state;
    logic [ADDR_W:0]  tx;
    logic [BCW-1:0]   bcnt;
    logic [HCW-1:0]   hcnt;

    assign di      = tx[ADDR_W];
    assign busy    = (state != ST_IDLE);
    assign sclk_en = (state != ST_IDLE) && (state != ST_HOLD);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            tx         <= '0;
            bcnt       <= '0;
            hcnt       <= '0;
            cs_n       <= 1'b1;
            se_n       <= 1'b1;
            done       <= 1'b0;
            msb_word   <= '0;
            lsb_stream <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    state      <= ST_ADDR;
                    cs_n       <= 1'b0;
                    tx         <= {1'b1, addr_code(req)};
                    bcnt       <= '0;
                    msb_word   <= '0;
                    lsb_stream <= '0;
                end
                ST_ADDR: if (fall_p) begin
                    tx <= {tx[ADDR_W-1:0], 1'b0};
                    if (bcnt == BCW'(ADDR_W)) begin
                        state <= ST_WAIT;
                        bcnt  <= '0;
                    end else begin
                        bcnt <= bcnt + 1'b1;
                    end
                end
                ST_WAIT: if (rise_p && adc_status) begin
                    msb_word <= {msb_word[WORD_W-2:0], adc_do};
                    bcnt     <= BCW'(1);
                    state    <= ST_MSB;
                end
                ST_MSB: if (rise_p) begin
                    msb_word <= {msb_word[WORD_W-2:0], adc_do};
                    if (bcnt == BCW'(WORD_W - 1)) begin
                        state <= ST_SE;
                        bcnt  <= '0;
                    end else begin
                        bcnt <= bcnt + 1'b1;
                    end
                end
                ST_SE: if (fall_p) begin
                    se_n  <= 1'b0;
                    state <= ST_LSB;
                end
                ST_LSB: if (rise_p) begin
                    lsb_stream <= {lsb_stream[WORD_W-2:0], adc_do};
                    bcnt       <= bcnt + 1'b1;
                    if (bcnt == BCW'(WORD_W - 1)) state <= ST_FIN;
                end
                ST_FIN: if (fall_p) begin
                    cs_n  <= 1'b1;
                    se_n  <= 1'b1;
                    done  <= 1'b1;
                    bcnt  <= '0;
                    hcnt  <= '0;
                    state <= ST_HOLD;
                end
                ST_HOLD: begin
                    if (hcnt == HCW'(HOLD_CYC - 1)) state <= ST_IDLE;
                    else                            hcnt  <= hcnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R10: a request during the release hold neither lowers select nor restarts
    a_r10_hold_ignores_req: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && req_valid) |=> (cs_n && (state == ST_HOLD || state == ST_IDLE)));

    // R7: the replay is only sampled with shift-enable already asserted
    a_r7_replay_with_se: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LSB && rise_p) |-> !se_n);

endmodule

// File: rtl/adc_word_check.sv
module adc_word_check
    import adc_host_pkg::*;
(
    input  logic [WORD_W-1:0] msb_word,
    input  logic [WORD_W-1:0] lsb_stream,
    output logic              mismatch
);
    logic [WORD_W-1:0] rev;

    for (genvar i = 0; i < WORD_W; i++) begin : g_rev
        assign rev[i] = lsb_stream[WORD_W-1-i];
    end

    assign mismatch = (rev != msb_word);

endmodule

// File: rtl/adc_serial_host.sv
module adc_serial_host
    import adc_host_pkg::*;
#(
    parameter longint unsigned SYS_CLK_HZ = 200_000_000,
    parameter int unsigned     HALF_DIV   = 170,
    parameter int unsigned     CS_HIGH_NS = 220
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_single,
    input  logic [CHAN_W-1:0] req_chan,
    input  logic              req_swap,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] result,
    output logic              mismatch,
    output logic              adc_cs_n,
    output logic              adc_sclk,
    output logic              adc_di,
    output logic              adc_se_n,
    input  logic              adc_do,
    input  logic              adc_status
);
    localparam int unsigned HALF_EFF = clamp_half(SYS_CLK_HZ, longint'(HALF_DIV));
    localparam int unsigned HOLD_CYC = hold_cycles(SYS_CLK_HZ, longint'(CS_HIGH_NS));
    localparam int unsigned KCW      = $clog2(HOLD_CYC + 1);

    conv_req_t         req;
    logic              rise_p;
    logic              fall_p;
    logic              sclk_en;
    logic [WORD_W-1:0] lsb_stream;

    assign req = '{single: req_single, chan: req_chan, swap: req_swap};

    adc_sclk_gen #(.HALF(HALF_EFF)) u_clk (
        .clk    (clk),
        .rst    (rst),
        .en     (sclk_en),
        .sclk   (adc_sclk),
        .rise_p (rise_p),
        .fall_p (fall_p)
    );

    adc_host_seq #(.HOLD_CYC(HOLD_CYC)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req        (req),
        .rise_p     (rise_p),
        .fall_p     (fall_p),
        .adc_do     (adc_do),
        .adc_status (adc_status),
        .cs_n       (adc_cs_n),
        .di         (adc_di),
        .se_n       (adc_se_n),
        .busy       (busy),
        .sclk_en    (sclk_en),
        .done       (done),
        .msb_word   (result),
        .lsb_stream (lsb_stream)
    );

    adc_word_check u_chk (
        .msb_word   (result),
        .lsb_stream (lsb_stream),
        .mismatch   (mismatch)
    );

    // Saturating count of cycles the select line has been high.
    logic [KCW-1:0] hi_cnt;
    always_ff @(posedge clk) begin
        if (rst)                             hi_cnt <= KCW'(HOLD_CYC);
        else if (!adc_cs_n)                  hi_cnt <= '0;
        else if (hi_cnt != KCW'(HOLD_CYC))   hi_cnt <= hi_cnt + 1'b1;
    end

    // R9: a new select pulse only after the minimum high time
    a_r9_cs_high_min: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_cs_n) |-> (hi_cnt == KCW'(HOLD_CYC)));

    // R2: select low always reported as busy
    a_r2_cs_implies_busy: assert property (@(posedge clk) disable iff (rst)
        !adc_cs_n |-> busy);

    // R3: data to the converter is steady at every rising serial edge
    a_r3_di_steady_at_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_sclk) |-> $stable(adc_di));

    // R6: shift-enable only asserted inside a select pulse
    a_r6_se_inside_cs: assert property (@(posedge clk) disable iff (rst)
        !adc_se_n |-> !adc_cs_n);

    // R8: completion strobe coincides with select release
    a_r8_done_on_cs_rise: assert property (@(posedge clk) disable iff (rst)
        done |-> $rose(adc_cs_n));

endmodule

// File: tb/tb_adc_serial_host.sv
module tb_adc_serial_host;

    localparam int unsigned HALF_EXP = 167;
    localparam int unsigned HOLD_EXP = 44;

    logic       clk = 1'b0;
    logic       rst;
    logic       req_valid;
    logic       req_single;
    logic [2:0] req_chan;
    logic       req_swap;
    logic       busy, done, mismatch;
    logic [7:0] result;
    logic       adc_cs_n, adc_sclk, adc_di, adc_se_n;
    logic       adc_do;
    logic       adc_status;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    adc_serial_host #(
        .SYS_CLK_HZ (200_000_000),
        .HALF_DIV   (100),
        .CS_HIGH_NS (220)
    ) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_single(req_single),
        .req_chan(req_chan), .req_swap(req_swap), .busy(busy), .done(done),
        .result(result), .mismatch(mismatch), .adc_cs_n(adc_cs_n),
        .adc_sclk(adc_sclk), .adc_di(adc_di), .adc_se_n(adc_se_n),
        .adc_do(adc_do), .adc_status(adc_status)
    );

    // Behavioural converter
    int         r_rise, r_fall, r_se_rise;
    bit         r_se_low;
    logic [4:0] r_addr;
    logic [7:0] r_val, r_mask;

    always @(posedge adc_sclk) begin
        if (!adc_cs_n) begin
            r_rise = r_rise + 1;
            if (r_rise <= 5) r_addr = {r_addr[3:0], adc_di};
            if (!adc_se_n && r_se_rise == 0) r_se_rise = r_rise;
            r_se_low = !adc_se_n;
        end
    end

    always @(negedge adc_sclk) begin
        r_fall = r_fall + 1;
        if (r_fall == 5) begin
            adc_status = 1'b1;
            adc_do     = r_val[7];
        end else if (r_fall >= 6 && r_fall <= 12) begin
            adc_do = r_val[12 - r_fall];
        end else if (r_fall == 13) begin
            adc_status = 1'b0;
        end else if (r_fall >= 14 && r_se_low) begin
            if (r_fall - 13 <= 7) adc_do = r_val[r_fall - 13] ^ r_mask[r_fall - 13];
            else                  adc_do = 1'b0;
        end
    end

    // Phase-length monitor
    int  gap = 0;
    int  div_err = 0;
    logic prev_sclk = 1'b0, prev_cs = 1'b1;
    always @(negedge clk) begin
        if (prev_cs && !adc_cs_n) begin
            gap = 0;
        end else begin
            gap = gap + 1;
            if (adc_sclk != prev_sclk) begin
                if (gap != HALF_EXP) div_err = div_err + 1;
                gap = 0;
            end
        end
        prev_sclk = adc_sclk;
        prev_cs   = adc_cs_n;
    end

    function automatic logic [3:0] exp_addr(logic single, logic [2:0] ch, logic swap);
        return {single, single ? ch[0] : swap, ch[2], ch[1]};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic convert(logic single, logic [2:0] ch, logic swap,
                           logic [7:0] val, logic [7:0] mask, bit poke_hold);
        int n;
        r_rise = 0; r_fall = 0; r_se_rise = 0; r_se_low = 1'b0;
        r_addr = '0; r_val = val; r_mask = mask;
        adc_do = 1'b0; adc_status = 1'b0;
        div_err = 0;
        @(negedge clk);
        req_valid = 1'b1; req_single = single; req_chan = ch; req_swap = swap;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 cs_n low after accept", adc_cs_n, 1'b0);
        check("R2 busy after accept", busy, 1'b1);
        while (!done) @(negedge clk);
        check("R5 result word", result, val);
        check("R7 mismatch flag", mismatch, (mask != 0));
        check("R3 start+address", r_addr, {1'b1, exp_addr(single, ch, swap)});
        check("R6 first rise seeing se_n low", r_se_rise, 14);
        check("R8 rising edges in transaction", r_rise, 21);
        check("R8 cs_n high with done", adc_cs_n, 1'b1);
        check("R4 phase length errors", div_err, 0);
        check("R9 busy at done", busy, 1'b1);
        n = 0;
        while (busy) begin
            if (poke_hold && n < 5) begin
                req_valid = 1'b1; req_single = 1'b1; req_chan = 3'd5; req_swap = 1'b0;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
            n++;
            if (busy && adc_cs_n !== 1'b1) check("R10 cs_n held high during hold", adc_cs_n, 1'b1);
        end
        req_valid = 1'b0;
        check("R9 hold length", n, HOLD_EXP);
        check("R10 cs_n after hold", adc_cs_n, 1'b1);
        check("R8 done single cycle", done, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        req_valid = 0; req_single = 0; req_chan = 0; req_swap = 0;
        adc_do = 0; adc_status = 0;
        r_rise = 0; r_fall = 0; r_se_rise = 0; r_se_low = 0;
        r_addr = 0; r_val = 0; r_mask = 0;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 cs_n in reset", adc_cs_n, 1'b1);
        rst = 1'b0;
        @(negedge clk);
        check("R1 cs_n", adc_cs_n, 1'b1);
        check("R1 se_n", adc_se_n, 1'b1);
        check("R1 sclk", adc_sclk, 1'b0);
        check("R1 busy", busy, 1'b0);
        check("R1 done", done, 1'b0);

        convert(1'b1, 3'd0, 1'b0, 8'h00, 8'h00, 1'b0);
        convert(1'b0, 3'd6, 1'b1, 8'hFF, 8'h00, 1'b1);
        convert(1'b1, 3'd7, 1'b0, 8'hA5, 8'h10, 1'b0);
        convert(1'b0, 3'd2, 1'b0, 8'h3C, 8'h80, 1'b0);
        for (int i = 0; i < 8; i++) begin
            logic [7:0] m;
            m = ($urandom % 3 == 0) ? (8'h02 << ($urandom % 7)) : 8'h00;
            convert(1'($urandom), 3'($urandom), 1'($urandom), 8'($urandom), m, 1'($urandom));
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule